// File: doc/BRIEF.md
# Terminal Address Latch and Parity Check

This block holds the bus address of a terminal. A 5-bit address and one parity bit come in on external pins. A latch-control input, when low, lets the stored copy follow those pins. When the input goes high, the stored copy freezes on the last value that was present while the input was low. The latch-control input is asynchronous to the block clock, so it passes through a synchronizer. The address and parity pins run through a pipeline of the same depth, so that data and control stay aligned cycle for cycle.

The six stored bits must hold an odd number of ones. The block reports this on a parity-status output that is high when the address is usable. A received command-word address field, qualified by a valid strobe, is compared with the stored address. A one-cycle match pulse is raised only when the two are equal and the parity status is high. Reset clears the stored bits to zero. Zero has even parity, so the terminal answers no command until a good address has been loaded.

Top module: `term_addr_guard`

## Requirements
- R1: While the latch-control input is low, the stored address and parity bit take the values on the pins. A pin value applied just after clock edge n appears on the outputs after edge n+SYNC_STAGES+1.
- R2: While the synchronized latch-control input is high, changes on the address and parity pins have no effect on the stored address or on the parity status.
- R3: When the latch-control input and the pins change together, the stored value is the pin value from the last cycle in which the control input was sampled low.
- R4: While the active-low reset is asserted, the stored address and parity bit are zero, the parity status is low and the match output is low.
- R5: The parity status output is 1 when the count of ones over the five stored address bits plus the stored parity bit is odd, and 0 when that count is even.
- R6: A command strobe whose address equals the stored address, sampled while the parity status is 1, produces a match output of 1 for exactly the one cycle after that edge.
- R7: While the parity status is 0, the match output stays 0 even for a command whose address equals the stored address.
- R8: The match output is 0 after any edge at which the command strobe was low or the command address differed from the stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrPins | input | ADDR_W | Terminal address from the pins |
| parityPin | input | 1 | Address parity bit from its pin |
| holdLatch | input | 1 | Latch control: low = track the pins, high = hold |
| cmdValid | input | 1 | Strobe that marks a received command address as valid |
| cmdAddr | input | ADDR_W | Address field of the received command word |
| parityOk | output | 1 | 1 = stored bits have odd parity, so recognition is enabled |
| storedAddr | output | ADDR_W | Stored terminal address |
| cmdMatch | output | 1 | One-cycle pulse: the command is addressed to this terminal |

## Verification
The bench goes after the moment the latch closes, changing pins and control in the same cycle. A design whose data path skipped the synchronizer delay would capture the new pins instead of the old ones. Pins that keep changing while the latch is held would reveal a load enable with the wrong polarity. A matching command sent while parity is even checks that the parity gate is really in the match path; a design without it would answer a bad address. Reset in the middle of operation checks that a clean block comes back with recognition disabled, rather than holding a stale address that still matches.

// File: rtl/term_addr_pkg.sv
package term_addr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;     // synchronized latch control is low: copy pins
    logic cmdSample;  // a command address is offered this cycle
  } addrCtl_t;

endpackage

// File: rtl/term_addr_ctl.sv
module term_addr_ctl
  import term_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     holdLatch,
  input  logic     cmdValid,
  output addrCtl_t ctl
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] holdPipe;

  // Resets to "hold" so that nothing loads before real pin values arrive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdPipe <= '1;
    end else begin
      holdPipe[0] <= holdLatch;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        holdPipe[i] <= holdPipe[i-1];
      end
    end
  end

  always_comb begin
    ctl.loadEn    = ~holdPipe[LAST];
    ctl.cmdSample = cmdValid;
  end

endmodule

// File: rtl/term_addr_dp.sv
module term_addr_dp
  import term_addr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrPins,
  input  logic              parityPin,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  addrCtl_t          ctl,
  output logic [ADDR_W:0]   pipeTail,
  output logic [ADDR_W-1:0] storedAddr,
  output logic              parityOk,
  output logic              cmdMatch
);

  localparam int WORD_W = ADDR_W + 1;
  localparam int LAST   = SYNC_STAGES - 1;

  logic [WORD_W-1:0] pinPipe [SYNC_STAGES];
  logic [WORD_W-1:0] storedWord;
  logic              addrEqual;

  // Pin pipeline kept as deep as the control synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) pinPipe[i] <= '0;
    end else begin
      pinPipe[0] <= {parityPin, addrPins};
      for (int i = 1; i < SYNC_STAGES; i++) pinPipe[i] <= pinPipe[i-1];
    end
  end

  assign pipeTail = pinPipe[LAST];

  // Latch modelled as an enabled register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           storedWord <= '0;
    else if (ctl.loadEn) storedWord <= pinPipe[LAST];
  end

  assign storedAddr = storedWord[ADDR_W-1:0];
  assign parityOk   = ^storedWord;
  assign addrEqual  = (cmdAddr == storedAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdMatch <= 1'b0;
    else       cmdMatch <= ctl.cmdSample & addrEqual & parityOk;
  end

endmodule

// File: rtl/term_addr_guard.sv
module term_addr_guard
  import term_addr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrPins,
  input  logic              parityPin,
  input  logic              holdLatch,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              parityOk,
  output logic [ADDR_W-1:0] storedAddr,
  output logic              cmdMatch
);

  addrCtl_t        ctlStb;
  logic [ADDR_W:0] pipeTail;

  term_addr_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .holdLatch (holdLatch),
    .cmdValid  (cmdValid),
    .ctl       (ctlStb)
  );

  term_addr_dp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .addrPins   (addrPins),
    .parityPin  (parityPin),
    .cmdAddr    (cmdAddr),
    .ctl        (ctlStb),
    .pipeTail   (pipeTail),
    .storedAddr (storedAddr),
    .parityOk   (parityOk),
    .cmdMatch   (cmdMatch)
  );

endmodule

// File: rtl/term_addr_chk.sv
module term_addr_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [ADDR_W-1:0] storedAddr,
  input logic              parityOk,
  input logic              cmdMatch,
  input logic              loadEn,
  input logic [ADDR_W:0]   pipeTail
);

  // R4
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (storedAddr == '0 && !parityOk && !cmdMatch));

  // R1
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> storedAddr == $past(pipeTail[ADDR_W-1:0]));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> ($stable(storedAddr) && $stable(parityOk)));

  // R6
  match_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAddr == storedAddr && parityOk) |=> cmdMatch);

  // R7
  bad_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    !parityOk |=> !cmdMatch);

  // R8
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid || cmdAddr != storedAddr) |=> !cmdMatch);

endmodule

bind term_addr_guard term_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdAddr    (cmdAddr),
  .storedAddr (storedAddr),
  .parityOk   (parityOk),
  .cmdMatch   (cmdMatch),
  .loadEn     (ctlStb.loadEn),
  .pipeTail   (pipeTail)
);

// File: tb/term_addr_guard_tb.sv
module term_addr_guard_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 5;
  localparam int SYNC_STAGES = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrPins = '0;
  logic              parityPin = 1'b0;
  logic              holdLatch = 1'b0;
  logic              cmdValid = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic              parityOk;
  logic [ADDR_W-1:0] storedAddr;
  logic              cmdMatch;

  int testsRun = 0;
  int testsFailed = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_addr_guard #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rstN(rstN), .addrPins(addrPins), .parityPin(parityPin),
    .holdLatch(holdLatch), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .parityOk(parityOk), .storedAddr(storedAddr), .cmdMatch(cmdMatch)
  );

  // Reference model: queues of the last SYNC_STAGES input samples
  logic [ADDR_W:0] pinQ[$];
  bit              holdQ[$];
  logic [ADDR_W:0] mWord = '0;
  bit              mMatch = 0;

  function automatic bit oddOnes(logic [ADDR_W:0] w);
    return ($countones(w) % 2) == 1;
  endfunction

  task automatic modelReset();
    pinQ.delete(); holdQ.delete();
    for (int i = 0; i < SYNC_STAGES; i++) begin
      pinQ.push_back('0); holdQ.push_back(1'b1);
    end
    mWord = '0; mMatch = 0;
  endtask

  initial modelReset();
  always @(negedge rstN) modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      mMatch = cmdValid && (cmdAddr == mWord[ADDR_W-1:0]) && oddOnes(mWord);
      if (!holdQ[0]) mWord = pinQ[0];
      void'(pinQ.pop_front()); void'(holdQ.pop_front());
      pinQ.push_back({parityPin, addrPins});
      holdQ.push_back(holdLatch);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!doneFlag) begin
      check(storedAddr == mWord[ADDR_W-1:0], "R1 model storedAddr", storedAddr, mWord[ADDR_W-1:0]);
      check(parityOk == oddOnes(mWord), "R5 model parityOk", parityOk, oddOnes(mWord));
      check(cmdMatch == mMatch, "R6 model cmdMatch", cmdMatch, mMatch);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendCmd(logic [ADDR_W-1:0] a, bit expMatch, string tag);
    cmdAddr = a; cmdValid = 1'b1;
    cyc(1);
    cmdValid = 1'b0;
    @(negedge clk);
    check(cmdMatch == expMatch, tag, cmdMatch, expMatch);
    @(negedge clk);
    check(cmdMatch == 1'b0, {tag, " pulse end"}, cmdMatch, 0);
    cyc(0);
  endtask

  task automatic finishRun();
    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    addrPins = 5'h0A; parityPin = 1'b1;
    cyc(3);
    @(negedge clk);
    // R4: reset state
    check(storedAddr == 0 && !parityOk && !cmdMatch, "R4 reset state", storedAddr, 0);
    cyc(0);
    rstN = 1'b1;
    cyc(SYNC_STAGES + 3);
    @(negedge clk);
    check(storedAddr == 5'h0A, "R1 tracks pins", storedAddr, 5'h0A);
    check(parityOk == 1'b1, "R5 odd parity 0A+1", parityOk, 1);
    cyc(0);
    sendCmd(5'h0A, 1'b1, "R6 match 0A");
    sendCmd(5'h0B, 1'b0, "R8 other address");
    cmdAddr = 5'h0A; cyc(1);
    @(negedge clk);
    check(cmdMatch == 1'b0, "R8 no strobe", cmdMatch, 0);
    cyc(0);

    // R2: hold, then wiggle pins
    holdLatch = 1'b1; cyc(SYNC_STAGES + 2);
    addrPins = 5'h15; parityPin = 1'b0; cyc(2);
    addrPins = 5'h00; parityPin = 1'b0; cyc(4);
    @(negedge clk);
    check(storedAddr == 5'h0A, "R2 held address", storedAddr, 5'h0A);
    check(parityOk == 1'b1, "R2 held parity", parityOk, 1);
    cyc(0);

    // R3: pins and control change together
    holdLatch = 1'b0; addrPins = 5'h03; parityPin = 1'b1; cyc(SYNC_STAGES + 3);
    addrPins = 5'h1C; parityPin = 1'b0; holdLatch = 1'b1; cyc(SYNC_STAGES + 4);
    @(negedge clk);
    check(storedAddr == 5'h03, "R3 last low value", storedAddr, 5'h03);
    cyc(0);

    // R7: even parity disables recognition
    holdLatch = 1'b0; addrPins = 5'h03; parityPin = 1'b0; cyc(SYNC_STAGES + 3);
    @(negedge clk);
    check(parityOk == 1'b0, "R5 even parity 03+0", parityOk, 0);
    cyc(0);
    sendCmd(5'h03, 1'b0, "R7 bad parity no match");

    // R5: more patterns
    addrPins = 5'h1F; parityPin = 1'b0; cyc(SYNC_STAGES + 3);
    @(negedge clk);
    check(parityOk == 1'b1, "R5 1F+0 odd", parityOk, 1);
    cyc(0);
    sendCmd(5'h1F, 1'b1, "R6 match 1F");
    addrPins = 5'h00; parityPin = 1'b1; cyc(SYNC_STAGES + 3);
    @(negedge clk);
    check(parityOk == 1'b1, "R5 00+1 odd", parityOk, 1);
    cyc(0);
    sendCmd(5'h00, 1'b1, "R6 match 00");

    // R4: reset mid-run
    rstN = 1'b0; cyc(2);
    @(negedge clk);
    check(storedAddr == 0 && !parityOk, "R4 reset mid-run", storedAddr, 0);
    cyc(0);
    sendCmd(5'h00, 1'b0, "R4 R7 no match in reset");
    rstN = 1'b1; holdLatch = 1'b1; cyc(SYNC_STAGES + 3);
    @(negedge clk);
    check(storedAddr == 0 && !parityOk, "R4 stays clear while held", storedAddr, 0);
    cyc(0);
    sendCmd(5'h00, 1'b0, "R7 zero address after reset");
    cyc(2);
    finishRun();
  end

endmodule